// File: doc/BRIEF.md
# Sixteen-Channel DMA Control Register Block

This block is the software-visible register file for a sixteen-channel DMA controller. A processor reaches it through two 32-bit slave windows. The main window is 4 KiB. It covers channels 0 to 14 and two global registers. A second 256-byte window carries only channel 15, with the same per-channel layout. The transfer engines are outside this block. They report completion and interrupt events on input strobes, and they present the fields of the descriptor they are working on as input vectors. The block shows these fields back to software as read-only registers.

Each channel has four kinds of state:
- a control/status word with stored fields, flags that software clears by writing one, and a self-clearing reset command;
- a control-block address that the engine picks up;
- a free debug word;
- a start strobe, raised in the same cycle as a write that turns the active bit from 0 to 1.

Interrupt requests from the engines are gathered into a 16-bit summary register and sixteen interrupt lines. Software acknowledges an interrupt through the channel's own control/status word. A 16-bit global enable register is brought out for the engines.

Top module: `dma_regfile`

## Requirements
- R1: After reset every control/status word, control-block address and debug word is zero, the interrupt summary and all interrupt lines are zero, and the global enable reads 0xFFFF.
- R2: In the main window, an offset below 0xF00 selects channel offset[11:8] and register offset[7:0]. The auxiliary window addresses channel 15 with the same register offsets. Main-window offsets from 0xF00 up, other than the two global registers, are unmapped.
- R3: The per-channel register offsets are: 0x00 control/status, 0x04 control-block address (read/write), 0x20 debug (read/write). Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C return the engine's descriptor inputs (info, source, destination, length, stride, next), and writes to them are ignored.
- R4: A control/status write loads only the bits set in mask 0x30FF0001 from the written word. Bit 0 is the active bit. Bit 30 has no effect, and no other bit is loaded from the data.
- R5: A control/status write with bit 31 set first clears the whole control/status word and the control-block address. The masked bits of the same write are then applied.
- R6: On a control/status write, a 1 in bit 1 clears the end flag (bit 1). A 1 in bit 2 clears the interrupt flag (bit 2), the channel's summary bit and its interrupt line.
- R7: The channel's start output is high, in the cycle of a control/status write, exactly when the stored active bit is 0 and bit 0 of the written data is 1.
- R8: An engine done strobe sets the end flag and clears the active bit. An engine interrupt strobe sets the interrupt flag, the summary bit and the interrupt line. A set takes priority over a software clear in the same cycle.
- R9: Offset 0xFE0 reads the 16-bit interrupt summary, one bit per channel, and writes to it are ignored. Offset 0xFF0 is the 16-bit global enable, readable and writable, and is driven on `chan_enable`.
- R10: Only accesses with size code 2'b10 (32-bit) take effect. Other sizes drop writes and read as zero. Reads of unmapped offsets return zero, and writes to them change nothing.
- R11: Read data is registered. It appears in the cycle after the request and is zero in any cycle after no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_req | input | 1 | Main window access request |
| main_we | input | 1 | Main window write (1) or read (0) |
| main_addr | input | 12 | Main window byte offset |
| main_size | input | 2 | Main window access size code, 2'b10 = 32-bit |
| main_wdata | input | 32 | Main window write data |
| main_rdata | output | 32 | Main window registered read data |
| aux_req | input | 1 | Channel-15 window access request |
| aux_we | input | 1 | Channel-15 window write (1) or read (0) |
| aux_addr | input | 8 | Channel-15 window byte offset |
| aux_size | input | 2 | Channel-15 window size code |
| aux_wdata | input | 32 | Channel-15 window write data |
| aux_rdata | output | 32 | Channel-15 window registered read data |
| eng_done | input | 16 | Per-channel block-complete strobe |
| eng_irq | input | 16 | Per-channel interrupt request strobe |
| desc_info | input | 512 | Per-channel descriptor info field, channel c at [32c+31:32c] |
| desc_src | input | 512 | Per-channel source address |
| desc_dst | input | 512 | Per-channel destination address |
| desc_len | input | 512 | Per-channel transfer length |
| desc_stride | input | 512 | Per-channel stride |
| desc_next | input | 512 | Per-channel next-descriptor address |
| cb_addr | output | 512 | Per-channel control-block address |
| chan_start | output | 16 | Per-channel start strobe |
| chan_enable | output | 16 | Global channel enable |
| irq | output | 16 | Per-channel interrupt lines |

## Verification
The bench mixes several kinds of control/status write in one word: a reset combined with a set active bit, write-one-to-clear bits combined with masked data, and a write to bit 30 alone. If the steps ran in the wrong order, the word or the control-block address would read back wrong. Start strobes are checked against a write that sets an active bit that is already 1; a design that decoded only bit 0 of the data would pulse again here. Engine interrupt strobes land in the same cycle as a software clear, and the bit must stay set. Out-of-window and narrow accesses are also covered: main-window offsets 0xF00 to 0xFFF other than the globals, writes to the read-only descriptor fields, and byte-size accesses. A loose decoder would alias or corrupt registers on these, or return nonzero data.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int DW = 32;

  // per-channel register offsets
  localparam logic [7:0] OFF_CS     = 8'h00;
  localparam logic [7:0] OFF_CB     = 8'h04;
  localparam logic [7:0] OFF_INFO   = 8'h08;
  localparam logic [7:0] OFF_SRC    = 8'h0C;
  localparam logic [7:0] OFF_DST    = 8'h10;
  localparam logic [7:0] OFF_LEN    = 8'h14;
  localparam logic [7:0] OFF_STRIDE = 8'h18;
  localparam logic [7:0] OFF_NEXT   = 8'h1C;
  localparam logic [7:0] OFF_DBG    = 8'h20;

  // control/status bits
  localparam int CS_ACT = 0;
  localparam int CS_END = 1;
  localparam int CS_INT = 2;
  localparam int CS_RST = 31;
  localparam logic [DW-1:0] CS_LOAD_MASK = 32'h30FF_0001;

  localparam logic [1:0] SIZE_WORD = 2'b10;

  // Next control/status value for a software write:
  // reset, then write-one-to-clear, then masked load.
  function automatic logic [DW-1:0] cs_after_write(input logic [DW-1:0] cur,
                                                   input logic [DW-1:0] wd);
    logic [DW-1:0] v;
    v = wd[CS_RST] ? '0 : cur;
    if (wd[CS_END]) v[CS_END] = 1'b0;
    if (wd[CS_INT]) v[CS_INT] = 1'b0;
    v = (v & ~CS_LOAD_MASK) | (wd & CS_LOAD_MASK);
    return v;
  endfunction

  // Read value of one channel register at a given offset.
  function automatic logic [DW-1:0] chan_read(input logic [7:0] off,
                                              input logic [DW-1:0] cs,
                                              input logic [DW-1:0] cb,
                                              input logic [DW-1:0] info,
                                              input logic [DW-1:0] src,
                                              input logic [DW-1:0] dst,
                                              input logic [DW-1:0] len,
                                              input logic [DW-1:0] stride,
                                              input logic [DW-1:0] nxt,
                                              input logic [DW-1:0] dbg);
    logic [DW-1:0] r;
    case (off)
      OFF_CS:     r = cs;
      OFF_CB:     r = cb;
      OFF_INFO:   r = info;
      OFF_SRC:    r = src;
      OFF_DST:    r = dst;
      OFF_LEN:    r = len;
      OFF_STRIDE: r = stride;
      OFF_NEXT:   r = nxt;
      OFF_DBG:    r = dbg;
      default:    r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dma_win_decode.sv
module dma_win_decode
  import dma_regs_pkg::*;
#(
  parameter int AW          = 12,
  parameter int NCH         = 16,
  parameter bit HAS_GLOBAL  = 1'b1,
  parameter int FIXED_CH    = 15,
  parameter int GLOB_BASE   = 'hF00,
  parameter int ISTAT_OFFS  = 'hFE0,
  parameter int ENABLE_OFFS = 'hFF0
) (
  input  logic                   req,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [1:0]             size,
  output logic                   acc_ok,
  output logic                   chan_acc,
  output logic [$clog2(NCH)-1:0] ch_idx,
  output logic [7:0]             off,
  output logic [NCH-1:0]         ch_wr,
  output logic                   istat_hit,
  output logic                   en_hit
);
  localparam int CW = $clog2(NCH);

  assign acc_ok = req && (size == SIZE_WORD);
  assign off    = addr[7:0];

  generate
    if (HAS_GLOBAL) begin : g_shared
      localparam logic [AW-1:0] GB = AW'(GLOB_BASE);
      localparam logic [AW-1:0] IS = AW'(ISTAT_OFFS);
      localparam logic [AW-1:0] EN = AW'(ENABLE_OFFS);
      assign chan_acc  = acc_ok && (addr < GB);
      assign ch_idx    = addr[8 +: CW];
      assign istat_hit = acc_ok && (addr == IS);
      assign en_hit    = acc_ok && (addr == EN);
    end else begin : g_single
      assign chan_acc  = acc_ok;
      assign ch_idx    = CW'(FIXED_CH);
      assign istat_hit = 1'b0;
      assign en_hit    = 1'b0;
    end
  endgenerate

  always_comb begin
    ch_wr = '0;
    if (chan_acc && we) ch_wr[ch_idx] = 1'b1;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [7:0]    off,
  input  logic [DW-1:0] wdata,
  input  logic          eng_done,
  input  logic          eng_irq,
  output logic          start,
  output logic          int_clr,
  output logic [DW-1:0] cs_q,
  output logic [DW-1:0] cb_q,
  output logic [DW-1:0] dbg_q
);
  logic          wr_cs;
  logic          cs_reset_cmd;
  logic [DW-1:0] cs_d;

  assign wr_cs        = wr && (off == OFF_CS);
  assign cs_reset_cmd = wr_cs && wdata[CS_RST];
  assign start        = wr_cs && wdata[CS_ACT] && !cs_q[CS_ACT];
  assign int_clr      = wr_cs && wdata[CS_INT];

  always_comb begin
    cs_d = cs_q;
    if (wr_cs) cs_d = cs_after_write(cs_q, wdata);
    if (eng_done) begin
      cs_d[CS_END] = 1'b1;
      cs_d[CS_ACT] = 1'b0;
    end
    if (eng_irq) cs_d[CS_INT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= '0;
      cb_q  <= '0;
      dbg_q <= '0;
    end else begin
      cs_q <= cs_d;
      if (cs_reset_cmd)                 cb_q <= '0;
      else if (wr && (off == OFF_CB))   cb_q <= wdata;
      if (wr && (off == OFF_DBG))       dbg_q <= wdata;
    end
  end

  // R7
  start_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !eng_done) |=> cs_q[CS_ACT]);

  // R5
  rst_cmd_clears_cb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_reset_cmd |=> (cb_q == '0));

  // R8
  done_sets_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (cs_q[CS_END] && !cs_q[CS_ACT]));

  // R8
  irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_irq |=> cs_q[CS_INT]);
endmodule

// File: rtl/dma_glob_regs.sv
module dma_glob_regs #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] int_set,
  input  logic [NCH-1:0] int_clr,
  input  logic           en_wr,
  input  logic [NCH-1:0] en_wdata,
  output logic [NCH-1:0] int_status,
  output logic [NCH-1:0] enable
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_status <= '0;
      enable     <= '1;
    end else begin
      int_status <= (int_status & ~int_clr) | int_set;
      if (en_wr) enable <= en_wdata;
    end
  end

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_set != '0) |=> ((int_status & $past(int_set)) == $past(int_set)));

  // R9
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_set == '0 && int_clr == '0) |=> $stable(int_status));

  // R9
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(enable));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regs_pkg::*;
#(
  parameter int NCH     = 16,
  parameter int MAIN_AW = 12,
  parameter int AUX_AW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               main_req,
  input  logic               main_we,
  input  logic [MAIN_AW-1:0] main_addr,
  input  logic [1:0]         main_size,
  input  logic [DW-1:0]      main_wdata,
  output logic [DW-1:0]      main_rdata,
  input  logic               aux_req,
  input  logic               aux_we,
  input  logic [AUX_AW-1:0]  aux_addr,
  input  logic [1:0]         aux_size,
  input  logic [DW-1:0]      aux_wdata,
  output logic [DW-1:0]      aux_rdata,
  input  logic [NCH-1:0]     eng_done,
  input  logic [NCH-1:0]     eng_irq,
  input  logic [NCH*DW-1:0]  desc_info,
  input  logic [NCH*DW-1:0]  desc_src,
  input  logic [NCH*DW-1:0]  desc_dst,
  input  logic [NCH*DW-1:0]  desc_len,
  input  logic [NCH*DW-1:0]  desc_stride,
  input  logic [NCH*DW-1:0]  desc_next,
  output logic [NCH*DW-1:0]  cb_addr,
  output logic [NCH-1:0]     chan_start,
  output logic [NCH-1:0]     chan_enable,
  output logic [NCH-1:0]     irq
);
  localparam int CW = $clog2(NCH);

  // main window decode
  logic           m_ok, m_chan, m_istat, m_en;
  logic [CW-1:0]  m_idx;
  logic [7:0]     m_off;
  logic [NCH-1:0] m_ch_wr;

  dma_win_decode #(.AW(MAIN_AW), .NCH(NCH), .HAS_GLOBAL(1'b1), .FIXED_CH(NCH-1))
  i_main_dec (
    .req(main_req), .we(main_we), .addr(main_addr), .size(main_size),
    .acc_ok(m_ok), .chan_acc(m_chan), .ch_idx(m_idx), .off(m_off),
    .ch_wr(m_ch_wr), .istat_hit(m_istat), .en_hit(m_en)
  );

  // channel-15 window decode
  logic           a_ok, a_chan, a_istat, a_en;
  logic [CW-1:0]  a_idx;
  logic [7:0]     a_off;
  logic [NCH-1:0] a_ch_wr;

  dma_win_decode #(.AW(AUX_AW), .NCH(NCH), .HAS_GLOBAL(1'b0), .FIXED_CH(NCH-1))
  i_aux_dec (
    .req(aux_req), .we(aux_we), .addr(aux_addr), .size(aux_size),
    .acc_ok(a_ok), .chan_acc(a_chan), .ch_idx(a_idx), .off(a_off),
    .ch_wr(a_ch_wr), .istat_hit(a_istat), .en_hit(a_en)
  );

  // channel state
  logic [DW-1:0]  cs_arr   [NCH];
  logic [DW-1:0]  cb_arr   [NCH];
  logic [DW-1:0]  dbg_arr  [NCH];
  logic [NCH-1:0] int_clr_vec;
  logic [NCH-1:0] int_status;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic          c_wr;
      logic [7:0]    c_off;
      logic [DW-1:0] c_wd;
      assign c_wr  = m_ch_wr[c] | a_ch_wr[c];
      assign c_off = a_ch_wr[c] ? a_off : m_off;
      assign c_wd  = a_ch_wr[c] ? aux_wdata : main_wdata;

      dma_chan_regs i_chan (
        .clk(clk), .rst_n(rst_n), .wr(c_wr), .off(c_off), .wdata(c_wd),
        .eng_done(eng_done[c]), .eng_irq(eng_irq[c]),
        .start(chan_start[c]), .int_clr(int_clr_vec[c]),
        .cs_q(cs_arr[c]), .cb_q(cb_arr[c]), .dbg_q(dbg_arr[c])
      );
      assign cb_addr[c*DW +: DW] = cb_arr[c];
    end
  endgenerate

  dma_glob_regs #(.NCH(NCH)) i_glob (
    .clk(clk), .rst_n(rst_n),
    .int_set(eng_irq), .int_clr(int_clr_vec),
    .en_wr(m_en && main_we), .en_wdata(main_wdata[NCH-1:0]),
    .int_status(int_status), .enable(chan_enable)
  );

  assign irq = int_status;

  // read value of a window access
  function automatic logic [DW-1:0] rd_value(input logic is_st, input logic is_en,
                                             input logic is_ch, input logic [CW-1:0] c,
                                             input logic [7:0] o);
    logic [DW-1:0] r;
    if (is_st)      r = DW'(int_status);
    else if (is_en) r = DW'(chan_enable);
    else if (is_ch) r = chan_read(o, cs_arr[c], cb_arr[c],
                                  desc_info[c*DW +: DW], desc_src[c*DW +: DW],
                                  desc_dst[c*DW +: DW], desc_len[c*DW +: DW],
                                  desc_stride[c*DW +: DW], desc_next[c*DW +: DW],
                                  dbg_arr[c]);
    else            r = '0;
    return r;
  endfunction

  logic m_rd, a_rd;
  assign m_rd = m_ok && !main_we;
  assign a_rd = a_ok && !aux_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_rdata <= '0;
      aux_rdata  <= '0;
    end else begin
      main_rdata <= m_rd ? rd_value(m_istat, m_en, m_chan, m_idx, m_off) : '0;
      aux_rdata  <= a_rd ? rd_value(a_istat, a_en, a_chan, a_idx, a_off) : '0;
    end
  end

  // R2
  main_skips_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_ch_wr[NCH-1]);

  // R11
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_req |=> (main_rdata == '0));

  // R10
  narrow_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_req && !aux_we && aux_size != SIZE_WORD) |=> (aux_rdata == '0));

  // R10
  narrow_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_req && main_we && main_size != SIZE_WORD && !aux_req)
      |=> ($stable(cb_addr) && $stable(chan_enable)));
endmodule

// File: tb/test_dma_regfile.sv
module test_dma_regfile;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        main_req = 0, main_we = 0;
  logic [11:0] main_addr = '0;
  logic [1:0]  main_size = 2'b10;
  logic [31:0] main_wdata = '0;
  logic [31:0] main_rdata;
  logic        aux_req = 0, aux_we = 0;
  logic [7:0]  aux_addr = '0;
  logic [1:0]  aux_size = 2'b10;
  logic [31:0] aux_wdata = '0;
  logic [31:0] aux_rdata;
  logic [NCH-1:0] eng_done = '0, eng_irq = '0;
  logic [NCH*32-1:0] desc_info, desc_src, desc_dst, desc_len, desc_stride, desc_next;
  logic [NCH*32-1:0] cb_addr;
  logic [NCH-1:0] chan_start, chan_enable, irq;

  always #2 clk = ~clk;

  dma_regfile i_dma_regfile (
    .clk(clk), .rst_n(rst_n),
    .main_req(main_req), .main_we(main_we), .main_addr(main_addr),
    .main_size(main_size), .main_wdata(main_wdata), .main_rdata(main_rdata),
    .aux_req(aux_req), .aux_we(aux_we), .aux_addr(aux_addr),
    .aux_size(aux_size), .aux_wdata(aux_wdata), .aux_rdata(aux_rdata),
    .eng_done(eng_done), .eng_irq(eng_irq),
    .desc_info(desc_info), .desc_src(desc_src), .desc_dst(desc_dst),
    .desc_len(desc_len), .desc_stride(desc_stride), .desc_next(desc_next),
    .cb_addr(cb_addr), .chan_start(chan_start), .chan_enable(chan_enable), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;

  // reference model
  logic [31:0] m_cs [NCH];
  logic [31:0] m_cb [NCH];
  logic [31:0] m_dbg[NCH];
  logic [15:0] m_ist;
  logic [15:0] m_en;

  function automatic logic [31:0] desc_val(input int c, input int k);
    return 32'hA000_0000 ^ (32'(k) << 20) ^ (32'(c) << 8) ^ 32'(c * 13 + k * 5);
  endfunction

  function automatic logic [31:0] model_read(input int c, input logic [7:0] o);
    case (o)
      8'h00: return m_cs[c];
      8'h04: return m_cb[c];
      8'h08: return desc_val(c, 0);
      8'h0C: return desc_val(c, 1);
      8'h10: return desc_val(c, 2);
      8'h14: return desc_val(c, 3);
      8'h18: return desc_val(c, 4);
      8'h1C: return desc_val(c, 5);
      8'h20: return m_dbg[c];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_main_rd(input logic [11:0] a, input logic [1:0] sz);
    if (sz != 2'b10) return 32'h0;
    if (a < 12'hF00) return model_read(int'(a[11:8]), a[7:0]);
    if (a == 12'hFE0) return {16'h0, m_ist};
    if (a == 12'hFF0) return {16'h0, m_en};
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_aux_rd(input logic [7:0] a, input logic [1:0] sz);
    if (sz != 2'b10) return 32'h0;
    return model_read(15, a);
  endfunction

  logic [15:0] clr_pend;

  task automatic model_chan_wr(input int c, input logic [7:0] o, input logic [31:0] wd);
    logic [31:0] t;
    if (o == 8'h00) begin
      t = m_cs[c];
      if (wd[31]) begin t = '0; m_cb[c] = '0; end
      if (wd[1]) t[1] = 1'b0;
      if (wd[2]) begin t[2] = 1'b0; clr_pend[c] = 1'b1; end
      for (int b = 0; b < 32; b++)
        if ((b == 0) || (b >= 16 && b <= 23) || b == 28 || b == 29) t[b] = wd[b];
      m_cs[c] = t;
    end else if (o == 8'h04) m_cb[c] = wd;
    else if (o == 8'h20) m_dbg[c] = wd;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One bus cycle on both windows plus engine strobes.
  task automatic step(input string tag,
                      input logic mr, input logic mw, input logic [11:0] ma,
                      input logic [1:0] ms, input logic [31:0] md,
                      input logic ar, input logic aw, input logic [7:0] aa,
                      input logic [1:0] as, input logic [31:0] ad,
                      input logic [15:0] dn, input logic [15:0] iq);
    logic [15:0] exp_start;
    logic [31:0] exp_mr, exp_ar;
    @(negedge clk);
    main_req = mr; main_we = mw; main_addr = ma; main_size = ms; main_wdata = md;
    aux_req = ar; aux_we = aw; aux_addr = aa; aux_size = as; aux_wdata = ad;
    eng_done = dn; eng_irq = iq;
    exp_start = '0;
    if (mr && mw && ms == 2'b10 && ma < 12'hF00 && ma[7:0] == 8'h00)
      exp_start[ma[11:8]] = md[0] && !m_cs[ma[11:8]][0];
    if (ar && aw && as == 2'b10 && aa == 8'h00)
      exp_start[15] = ad[0] && !m_cs[15][0];
    exp_mr = (mr && !mw) ? exp_main_rd(ma, ms) : 32'h0;
    exp_ar = (ar && !aw) ? exp_aux_rd(aa, as) : 32'h0;
    #1;
    chk({tag, " R7 start"}, {16'h0, chan_start}, {16'h0, exp_start});
    // model update
    clr_pend = '0;
    if (mr && mw && ms == 2'b10) begin
      if (ma < 12'hF00) model_chan_wr(int'(ma[11:8]), ma[7:0], md);
      else if (ma == 12'hFF0) m_en = md[15:0];
    end
    if (ar && aw && as == 2'b10) model_chan_wr(15, aa, ad);
    for (int c = 0; c < NCH; c++) begin
      if (dn[c]) begin m_cs[c][1] = 1'b1; m_cs[c][0] = 1'b0; end
      if (iq[c]) m_cs[c][2] = 1'b1;
    end
    m_ist = (m_ist & ~clr_pend) | iq;
    @(posedge clk);
    #1;
    chk({tag, " R11 main rdata"}, main_rdata, exp_mr);
    chk({tag, " R11 aux rdata"}, aux_rdata, exp_ar);
    chk({tag, " R8 irq"}, {16'h0, irq}, {16'h0, m_ist});
    chk({tag, " R9 enable"}, {16'h0, chan_enable}, {16'h0, m_en});
    for (int c = 0; c < NCH; c++)
      if (cb_addr[c*32 +: 32] !== m_cb[c]) chk({tag, " R5 cb_addr"}, cb_addr[c*32 +: 32], m_cb[c]);
  endtask

  task automatic mwr(input string tag, input logic [11:0] a, input logic [31:0] d);
    step(tag, 1, 1, a, 2'b10, d, 0, 0, 8'h0, 2'b10, 0, 16'h0, 16'h0);
  endtask
  task automatic mrd(input string tag, input logic [11:0] a);
    step(tag, 1, 0, a, 2'b10, 0, 0, 0, 8'h0, 2'b10, 0, 16'h0, 16'h0);
  endtask
  task automatic awr(input string tag, input logic [7:0] a, input logic [31:0] d);
    step(tag, 0, 0, 12'h0, 2'b10, 0, 1, 1, a, 2'b10, d, 16'h0, 16'h0);
  endtask
  task automatic ard(input string tag, input logic [7:0] a);
    step(tag, 0, 0, 12'h0, 2'b10, 0, 1, 0, a, 2'b10, 0, 16'h0, 16'h0);
  endtask

  function automatic logic [7:0] pick_off(input logic [31:0] r);
    case (r[3:0])
      0, 1, 2: return 8'h00;
      3, 4:    return 8'h04;
      5:       return 8'h20;
      6:       return 8'h08;
      7:       return 8'h1C;
      8:       return 8'h14;
      9:       return 8'h24;
      10:      return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++) begin
      desc_info[c*32 +: 32]   = desc_val(c, 0);
      desc_src[c*32 +: 32]    = desc_val(c, 1);
      desc_dst[c*32 +: 32]    = desc_val(c, 2);
      desc_len[c*32 +: 32]    = desc_val(c, 3);
      desc_stride[c*32 +: 32] = desc_val(c, 4);
      desc_next[c*32 +: 32]   = desc_val(c, 5);
      m_cs[c] = '0; m_cb[c] = '0; m_dbg[c] = '0;
    end
    m_ist = '0; m_en = 16'hFFFF;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    mrd("R1 enable reset", 12'hFF0);
    mrd("R1 status reset", 12'hFE0);
    mrd("R1 cs reset", 12'h300);
    ard("R1 ch15 cb reset", 8'h04);

    // R3 descriptor views and read-only behaviour
    mrd("R3 info ch3", 12'h308);
    mrd("R3 stride ch3", 12'h318);
    ard("R3 next ch15", 8'h1C);
    mwr("R3 write ro", 12'h314, 32'hDEAD_BEEF);
    mrd("R3 len after write", 12'h314);
    mwr("R3 debug", 12'h520, 32'h1234_5678);
    mrd("R3 debug rd", 12'h520);

    // R2 decoding and window separation
    mwr("R2 ch14 cb", 12'hE04, 32'h0000_4440);
    awr("R2 ch15 cb", 8'h04, 32'h0000_5550);
    mrd("R2 ch14 rd", 12'hE04);
    mrd("R2 unmapped F04", 12'hF04);
    mwr("R2 write F04", 12'hF04, 32'hFFFF_FFFF);
    ard("R2 ch15 rd", 8'h04);

    // R10 narrow access
    step("R10 byte write", 1, 1, 12'h104, 2'b00, 32'h55, 0, 0, 0, 2'b10, 0, 0, 0);
    mrd("R10 after byte write", 12'h104);
    step("R10 half read", 1, 0, 12'hE04, 2'b01, 0, 1, 0, 8'h04, 2'b00, 0, 0, 0);

    // R4 mask, abort ignored
    mwr("R4 all ones", 12'h200, 32'h7FFF_FFFE);
    mrd("R4 readback", 12'h200);
    mwr("R4 abort only", 12'h200, 32'h4000_0000);
    mrd("R4 abort readback", 12'h200);

    // R7 start edge
    mwr("R7 first start", 12'h100, 32'h0000_0001);
    mwr("R7 second start", 12'h100, 32'h0000_0001);
    awr("R7 ch15 start", 8'h00, 32'h0000_0001);

    // R5 reset cmd together with active
    mwr("R5 cb ch1", 12'h104, 32'h0000_1000);
    mwr("R5 reset+act", 12'h100, 32'h8000_0001);
    mrd("R5 cs rd", 12'h100);
    mrd("R5 cb rd", 12'h104);

    // R8 done, irq, set beats clear
    step("R8 done ch1", 0, 0, 0, 2'b10, 0, 0, 0, 0, 2'b10, 0, 16'h0002, 16'h0002);
    mrd("R8 cs after done", 12'h100);
    mrd("R8 status", 12'hFE0);
    step("R8 clear vs set", 1, 1, 12'h100, 2'b10, 32'h4, 0, 0, 0, 2'b10, 0, 0, 16'h0002);
    mrd("R8 status held", 12'hFE0);

    // R6 write-one-to-clear
    mwr("R6 clear int", 12'h100, 32'h0000_0004);
    mrd("R6 status cleared", 12'hFE0);
    mwr("R6 clear end", 12'h100, 32'h0000_0002);
    mrd("R6 cs", 12'h100);

    // R9 global registers
    mwr("R9 status write ignored", 12'hFE0, 32'hFFFF);
    mrd("R9 status", 12'hFE0);
    mwr("R9 enable write", 12'hFF0, 32'hABCD_1234);
    mrd("R9 enable rd", 12'hFF0);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a, b;
      logic [11:0] ma;
      logic [7:0]  aa;
      logic [31:0] md;
      a = $urandom; b = $urandom;
      if (a[31:28] == 4'hF) ma = a[0] ? 12'hFE0 : (a[1] ? 12'hFF0 : 12'hF00 | 12'(b[7:0]));
      else ma = {a[27:24] % 4'hF, pick_off(b)};
      aa = pick_off(b >> 8);
      md = $urandom;
      if (md[5:4] == 2'b00) md[31] = 1'b0;
      step("R4 random", a[8], a[9], ma, (a[12:10] == 0) ? 2'b00 : 2'b10, md,
           a[13], a[14], aa, (a[17:15] == 0) ? 2'b01 : 2'b10, $urandom,
           16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom));
    end

    @(negedge clk);
    main_req = 0; aux_req = 0; eng_done = '0; eng_irq = '0;
    r = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %h expected %h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule